// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder and Decoder

This block turns a stream of signed sample words into a one-bit-per-sample code and rebuilds an approximation of those words from that code. The encoder keeps a running estimate of the input. On every sample strobe it sends a 1 if the sample is above the estimate and a 0 otherwise. It then moves the estimate toward the sample by one step.

The step size grows while the code keeps repeating the same bit, so a steep slope is tracked quickly. It falls back to the smallest step as soon as the bits alternate, so a flat signal carries little granular noise.

The decoder holds its own copy of the estimate, its own bit history and its own gain counter, and updates them from the received bits alone. An encoder and a decoder reset together therefore produce the same estimate sequence. The decoder's rebuilt word is the raw estimate; any smoothing filter sits outside this block.

Top module: `adm_codec`

## Requirements
- R1: On a clock edge where `smpValid` is high, `encBit` becomes 1 if `smpIn` (two's complement) is strictly greater than the encoder estimate held before that edge, and 0 otherwise. `encBit` holds its value on edges where `smpValid` is low.
- R2: A processed bit of 1 raises the estimate and a processed bit of 0 lowers it.
- R3: The amount the estimate moves is BASE_STEP shifted left by the gain code. Gain 0 gives the base step, 1 gives twice the base step, 2 gives four times and 3 gives eight times. The step used for a bit is the one given by the gain code after that bit's gain update. The parameters must satisfy 8*BASE_STEP < 2^(SAMPLE_W-1).
- R4: If a processed bit equals both of the two bits processed just before it, the gain code increases by one.
- R5: Once the gain code is 3, it stays at 3 for as long as the run of equal bits continues.
- R6: A processed bit that differs from the previous bit sets the gain code to 0.
- R7: The decoder applies the same history, gain and estimate rules to `rxBit`, but only on edges where `rxValid` is high. At other edges `rxBit` has no effect. `recOut` shows the decoder estimate.
- R8: The estimate clamps at the limits of the signed range (-2^(SAMPLE_W-1) and 2^(SAMPLE_W-1)-1) and never wraps.
- R9: After reset, both estimates are 0, both gain codes are 0, `encBit` is 0 and the bit history is empty. A bit can only count toward a run once two bits have been processed since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for encoder and decoder |
| smpValid | input | 1 | Sample strobe for the encoder |
| smpIn | input | SAMPLE_W | Signed input sample |
| encBit | output | 1 | Registered encoder code bit |
| rxValid | input | 1 | Strobe for the decoder bit input, nominally mid-bit |
| rxBit | input | 1 | Received code bit |
| recOut | output | SAMPLE_W | Reconstructed signed sample (decoder estimate) |

## Verification
The bench builds the block with SAMPLE_W = 12 and BASE_STEP = 8. With these values the largest step is 64 and the rails are at +2047 and -2048, so runs of full-scale samples drive the estimate onto both limits within a few dozen samples.

Directed bit runs fed to the decoder walk the gain code through every value, hold it at saturation and then break the run, with each step size checked against absolute numbers. Seeded random samples are then looped from `encBit` back into the decoder half a sample period later. Those runs mix short and long runs of equal bits around a moving estimate.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef struct packed {
    logic       upd;
    logic       up;
    logic [1:0] gain;
  } adm_ctrl_t;
endpackage

// File: rtl/adm_ctrl.sv
module adm_ctrl
  import adm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bitValid,
  input  logic      bitIn,
  output adm_ctrl_t ctrl,
  output logic      lastBit
);
  logic [1:0] histBits;
  logic [1:0] histCnt;
  logic [1:0] gainQ;
  logic       runHit;
  logic [1:0] gainNext;

  assign runHit   = (histCnt == 2'd2) && (bitIn == histBits[0]) && (bitIn == histBits[1]);
  assign gainNext = runHit ? ((gainQ == 2'd3) ? 2'd3 : gainQ + 2'd1) : 2'd0;

  always_comb begin
    ctrl.upd  = bitValid;
    ctrl.up   = bitIn;
    ctrl.gain = gainNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      histBits <= 2'b00;
      histCnt  <= 2'd0;
      gainQ    <= 2'd0;
    end else if (bitValid) begin
      histBits <= {histBits[0], bitIn};
      histCnt  <= (histCnt == 2'd2) ? 2'd2 : histCnt + 2'd1;
      gainQ    <= gainNext;
    end
  end

  assign lastBit = histBits[0];

  assert_gain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bitValid && gainQ == 2'd3 && histCnt == 2'd2 && bitIn == histBits[0] && bitIn == histBits[1])
    |=> gainQ == 2'd3);

  assert_gain_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bitValid && histCnt != 2'd0 && bitIn != histBits[0]) |=> gainQ == 2'd0);

  assert_gain_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bitValid |=> $stable(gainQ));

  assert_hist_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bitValid && histCnt != 2'd2) |=> gainQ == 2'd0);
endmodule

// File: rtl/adm_dp.sv
module adm_dp
  import adm_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int BASE_STEP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  adm_ctrl_t           ctrl,
  output logic [SAMPLE_W-1:0] est
);
  localparam int SW = SAMPLE_W + 2;
  localparam logic signed [SW-1:0] MAX_V = SW'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [SW-1:0] MIN_V = -MAX_V - SW'(1);

  logic signed [SW-1:0] estExt;
  logic signed [SW-1:0] stepW;
  logic signed [SW-1:0] sumW;
  logic [SAMPLE_W-1:0]  estNext;

  assign estExt = SW'($signed(est));
  assign stepW  = $signed(SW'(BASE_STEP)) <<< ctrl.gain;
  assign sumW   = ctrl.up ? (estExt + stepW) : (estExt - stepW);

  always_comb begin
    if (sumW > MAX_V)      estNext = MAX_V[SAMPLE_W-1:0];
    else if (sumW < MIN_V) estNext = MIN_V[SAMPLE_W-1:0];
    else                   estNext = sumW[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        est <= '0;
    else if (ctrl.upd) est <= estNext;
  end

  assert_est_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.upd && ctrl.up) |=> $signed(est) >= $signed($past(est)));

  assert_est_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.upd && !ctrl.up) |=> $signed(est) <= $signed($past(est)));

  assert_est_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.upd |=> $stable(est));
endmodule

// File: rtl/adm_codec.sv
module adm_codec
  import adm_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int BASE_STEP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smpValid,
  input  logic [SAMPLE_W-1:0] smpIn,
  output logic                encBit,
  input  logic                rxValid,
  input  logic                rxBit,
  output logic [SAMPLE_W-1:0] recOut
);
  localparam int MAX_STEP = BASE_STEP * 8;

  adm_ctrl_t           encCtrl;
  adm_ctrl_t           decCtrl;
  logic [SAMPLE_W-1:0] estEnc;
  logic [SAMPLE_W-1:0] estDec;
  logic                encDecide;
  logic                decLast;

  initial begin
    assert_step_range_R3: assert (MAX_STEP < (1 << (SAMPLE_W - 1)));
  end

  assign encDecide = $signed(smpIn) > $signed(estEnc);

  adm_ctrl encCtrl_i (
    .clk(clk), .rst_n(rst_n), .bitValid(smpValid), .bitIn(encDecide),
    .ctrl(encCtrl), .lastBit(encBit)
  );

  adm_dp #(.SAMPLE_W(SAMPLE_W), .BASE_STEP(BASE_STEP)) encDp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(encCtrl), .est(estEnc)
  );

  adm_ctrl decCtrl_i (
    .clk(clk), .rst_n(rst_n), .bitValid(rxValid), .bitIn(rxBit),
    .ctrl(decCtrl), .lastBit(decLast)
  );

  adm_dp #(.SAMPLE_W(SAMPLE_W), .BASE_STEP(BASE_STEP)) decDp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(decCtrl), .est(estDec)
  );

  assign recOut = estDec;

  assert_enc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !smpValid |=> $stable(encBit));

  assert_dec_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> decLast == $past(rxBit));
endmodule

// File: tb/adm_codec_tb_top.sv
module adm_codec_tb_top;
  localparam int W    = 12;
  localparam int BASE = 8;
  localparam int MAXV = (1 << (W - 1)) - 1;
  localparam int MINV = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smpValid = 1'b0;
  logic [W-1:0] smpIn = '0;
  logic         encBit;
  logic         rxValid = 1'b0;
  logic         rxBit = 1'b0;
  logic [W-1:0] recOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mEst[2];
  int mGain[2];
  int mH0[2];
  int mH1[2];
  int mCnt[2];

  always #10 clk = ~clk;

  adm_codec #(.SAMPLE_W(W), .BASE_STEP(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .smpValid(smpValid), .smpIn(smpIn),
    .encBit(encBit), .rxValid(rxValid), .rxBit(rxBit), .recOut(recOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mReset();
    for (int i = 0; i < 2; i++) begin
      mEst[i] = 0; mGain[i] = 0; mH0[i] = 0; mH1[i] = 0; mCnt[i] = 0;
    end
  endtask

  task automatic mStep(input int idx, input int b);
    int st;
    if (mCnt[idx] == 2 && b == mH0[idx] && b == mH1[idx])
      mGain[idx] = (mGain[idx] == 3) ? 3 : mGain[idx] + 1;
    else
      mGain[idx] = 0;
    st = BASE << mGain[idx];
    mEst[idx] = b ? mEst[idx] + st : mEst[idx] - st;
    if (mEst[idx] > MAXV) mEst[idx] = MAXV;
    if (mEst[idx] < MINV) mEst[idx] = MINV;
    mH1[idx] = mH0[idx];
    mH0[idx] = b;
    mCnt[idx] = (mCnt[idx] == 2) ? 2 : mCnt[idx] + 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; smpValid = 1'b0; rxValid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mReset();
    @(negedge clk);
  endtask

  task automatic decBit(input int b, input string req);
    rxBit = b[0]; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    mStep(1, b);
    chk(req, $signed(recOut), mEst[1]);
  endtask

  // one sample: encoder strobe, then decoder strobe half a sample later
  task automatic sample(input int v, input string req);
    int expBit;
    expBit = (v > mEst[0]) ? 1 : 0;
    smpIn = W'(v); smpValid = 1'b1;
    @(negedge clk);
    smpValid = 1'b0;
    mStep(0, expBit);
    chk({req, " R1 encBit"}, int'(encBit), expBit);
    @(negedge clk);
    rxBit = encBit; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    mStep(1, expBit);
    chk({req, " R7 recOut"}, $signed(recOut), mEst[1]);
    @(negedge clk);
  endtask

  initial begin
    int v;
    void'($urandom(32'd4711));
    mReset();
    doReset();
    // R9 reset state
    chk("R9 encBit after reset", int'(encBit), 0);
    chk("R9 recOut after reset", $signed(recOut), 0);

    // R3 R4 R5 R6: directed decoder run, absolute values
    decBit(1, "R9 first bit base step");   chk("R3 est 8", $signed(recOut), 8);
    decBit(1, "R9 second bit base step");  chk("R3 est 16", $signed(recOut), 16);
    decBit(1, "R4 gain 1");                chk("R4 est 32", $signed(recOut), 32);
    decBit(1, "R4 gain 2");                chk("R4 est 64", $signed(recOut), 64);
    decBit(1, "R3 gain 3");                chk("R3 est 128", $signed(recOut), 128);
    decBit(1, "R5 gain held");             chk("R5 est 192", $signed(recOut), 192);
    decBit(0, "R6 run broken");            chk("R6 est 184", $signed(recOut), 184);
    decBit(0, "R6 no run yet");            chk("R6 est 176", $signed(recOut), 176);
    decBit(0, "R4 new run");               chk("R4 est 160", $signed(recOut), 160);

    // R7: rxBit toggling without rxValid has no effect
    for (int i = 0; i < 6; i++) begin
      rxBit = i[0];
      @(negedge clk);
    end
    chk("R7 idle rxBit ignored", $signed(recOut), 160);
    decBit(0, "R7 history kept across idle"); chk("R7 est 128", $signed(recOut), 128);
    // R1: encoder untouched while smpValid low
    chk("R1 encBit held", int'(encBit), 0);

    doReset();
    // R8 upper rail
    for (int i = 0; i < 45; i++) sample(MAXV, "R8 high");
    chk("R8 clamp high", $signed(recOut), MAXV);
    // R8 lower rail
    for (int i = 0; i < 80; i++) sample(MINV, "R8 low");
    chk("R8 clamp low", $signed(recOut), MINV);
    // R2: flat zero input gives alternating bits
    for (int i = 0; i < 40; i++) sample(0, "R2 flat");

    // random walk mixed with jumps
    v = 0;
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 8) == 0) v = int'($urandom % 4096) - 2048;
      else v = v + int'($urandom % 129) - 64;
      if (v > MAXV) v = MAXV;
      if (v < MINV) v = MINV;
      sample(v, "R2 R3 random");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule